// File: doc/BRIEF.md
# Source Operand Address Generator with Constant Generator

This unit sits in the operand stage of a small 16-bit processor core. For each instruction it receives the number of the source register, the two-bit addressing mode, the byte/word flag, the current contents of the selected register and the extension word that follows the instruction. From these it decides how the source operand is obtained: taken straight from the register, read from a computed memory address, taken from the extension word as an immediate, or produced from a fixed constant with no memory traffic at all. It also reports whether the extension word is consumed, and it produces the post-increment value for the base register when the auto-increment mode is used.

Two register numbers are special. The program counter turns indexed mode into PC-relative addressing and auto-increment mode into an immediate operand. The status register turns indexed mode into absolute addressing with a zero base, and its two indirect modes, together with all four modes of the dedicated constant register, return fixed constants. When an extension word is consumed, the caller advances the program counter by one word at the end of the operand phase. The register file and the memory are outside this unit.

All results are registered: a request presented with `in_valid` in one clock cycle shows up on the outputs, with `out_valid`, after the next rising edge.

Top module: `srcag_top`

## Requirements
- R1: In register mode (mode 0) on a register other than the constant register, the result kind is 0 (register), `out_data` equals `reg_val` regardless of the byte flag, and none of `mem_req`, `ext_fetch`, `upd_en` is raised.
- R2: In indexed mode (mode 1) on an ordinary register, the result kind is 1 (memory), `out_data` is `reg_val + ext_word` modulo 2^16, and both `mem_req` and `ext_fetch` are raised.
- R3: In indexed mode on the program counter (register 0), the address is the program counter value plus the extension word, with kind 1, `mem_req` and `ext_fetch` raised.
- R4: In indexed mode on the status register (register 2), the address is the extension word alone; `reg_val` has no effect; kind 1, `mem_req` and `ext_fetch` raised.
- R5: In indirect mode (mode 2) on any register other than registers 2 and 3, including the program counter, the address is `reg_val`, kind 1, `mem_req` raised, no extension fetch and no register update.
- R6: In auto-increment mode (mode 3) on a register other than registers 0, 2 and 3, the address is `reg_val`, `mem_req` and `upd_en` are raised, and `upd_val` is `reg_val + 1` for a byte operation or `reg_val + 2` for a word operation, modulo 2^16.
- R7: Auto-increment mode on the program counter gives kind 3 (immediate) with `out_data` equal to `ext_word`, `ext_fetch` raised, and neither `mem_req` nor `upd_en`.
- R8: The constant register (register 3) gives kind 2 (constant) with values 0, 1, 2 and 0xFFFF for modes 0, 1, 2, 3; the status register gives 4 in mode 2 and 8 in mode 3. A constant never raises `mem_req`, `ext_fetch` or `upd_en`, and `reg_val` and `ext_word` have no effect on it.
- R9: A constant selected with the byte flag set is cut to its low 8 bits (so the all-ones constant becomes 0x00FF).
- R10: Outputs follow a request by exactly one clock edge; `out_valid` mirrors `in_valid` of the previous cycle, and while `out_valid` is low the three strobes are low.
- R11: A synchronous active-high reset clears `out_valid`, `out_kind`, `out_data`, the strobes and `upd_val` to zero at the next edge, even when a request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A request is present this cycle |
| src_idx | input | 4 | Source register number |
| src_mode | input | 2 | Source addressing mode |
| byte_op | input | 1 | 1 for a byte operation, 0 for a word operation |
| reg_val | input | 16 | Contents of the selected register |
| ext_word | input | 16 | Extension word following the instruction |
| out_valid | output | 1 | Result registers hold a new result |
| out_kind | output | 2 | 0 register, 1 memory address, 2 constant, 3 immediate |
| out_data | output | 16 | Operand, address, constant or immediate |
| mem_req | output | 1 | A memory read at `out_data` is needed |
| ext_fetch | output | 1 | The extension word is consumed; PC advances one word |
| upd_en | output | 1 | Write `upd_val` back to the source register |
| upd_val | output | 16 | Post-increment register value |

## Verification
The main function is driven from a vector table that crosses each of the four modes with an ordinary register, the program counter, the status register and the constant register, so that every special-register remapping is told apart from the general rule it overrides. Register and extension values are chosen so that a wrong base (register instead of zero, or extension ignored) or a missing carry wrap gives a visibly different address, and constant selections carry non-zero register and extension values to expose any leak of those inputs. Byte and word variants of auto-increment and of the all-ones constant separate the step size from the truncation rule. Directed tests then cover reset, idle cycles, back-to-back requests and reset arriving with a request.

// File: rtl/srcag_pkg.sv
package srcag_pkg;
  typedef enum logic [1:0] {
    SK_REG   = 2'd0,
    SK_MEM   = 2'd1,
    SK_CONST = 2'd2,
    SK_IMM   = 2'd3
  } src_kind_e;

  localparam logic [1:0] MD_REG  = 2'd0;
  localparam logic [1:0] MD_IDX  = 2'd1;
  localparam logic [1:0] MD_IND  = 2'd2;
  localparam logic [1:0] MD_INC  = 2'd3;
endpackage

// File: rtl/srcag_cgen.sv
module srcag_cgen #(
  parameter int DATA_W = 16,
  parameter int REG_AW = 4,
  parameter int SR_IDX = 2,
  parameter int CG_IDX = 3
) (
  input  logic [REG_AW-1:0] src_idx,
  input  logic [1:0]        src_mode,
  input  logic              byte_op,
  output logic              cg_hit,
  output logic [DATA_W-1:0] cg_value
);
  import srcag_pkg::*;

  localparam logic [DATA_W-1:0] BYTE_MASK = {{(DATA_W-8){1'b0}}, 8'hFF};

  logic              on_cg;
  logic              on_sr;
  logic [DATA_W-1:0] raw;

  assign on_cg  = (src_idx == REG_AW'(CG_IDX));
  assign on_sr  = (src_idx == REG_AW'(SR_IDX));
  assign cg_hit = on_cg || (on_sr && src_mode[1]);

  always_comb begin
    raw = '0;
    if (on_cg) begin
      case (src_mode)
        MD_REG:  raw = '0;
        MD_IDX:  raw = DATA_W'(1);
        MD_IND:  raw = DATA_W'(2);
        default: raw = '1;
      endcase
    end else if (on_sr) begin
      raw = (src_mode == MD_INC) ? DATA_W'(8) : DATA_W'(4);
    end
  end

  assign cg_value = byte_op ? (raw & BYTE_MASK) : raw;
endmodule

// File: rtl/srcag_ea.sv
module srcag_ea #(
  parameter int DATA_W = 16,
  parameter int REG_AW = 4,
  parameter int PC_IDX = 0,
  parameter int SR_IDX = 2
) (
  input  logic [REG_AW-1:0] src_idx,
  input  logic [1:0]        src_mode,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [DATA_W-1:0] ext_word,
  output logic [1:0]        ea_kind,
  output logic [DATA_W-1:0] ea_data,
  output logic              ea_mem,
  output logic              ea_ext
);
  import srcag_pkg::*;

  logic              on_pc;
  logic              on_sr;
  logic [DATA_W-1:0] base;

  assign on_pc = (src_idx == REG_AW'(PC_IDX));
  assign on_sr = (src_idx == REG_AW'(SR_IDX));
  assign base  = on_sr ? '0 : reg_val;

  always_comb begin
    ea_kind = SK_REG;
    ea_data = reg_val;
    ea_mem  = 1'b0;
    ea_ext  = 1'b0;
    case (src_mode)
      MD_REG: begin
        ea_kind = SK_REG;
        ea_data = reg_val;
      end
      MD_IDX: begin
        ea_kind = SK_MEM;
        ea_data = base + ext_word;
        ea_mem  = 1'b1;
        ea_ext  = 1'b1;
      end
      MD_IND: begin
        ea_kind = SK_MEM;
        ea_data = reg_val;
        ea_mem  = 1'b1;
      end
      default: begin
        if (on_pc) begin
          ea_kind = SK_IMM;
          ea_data = ext_word;
          ea_ext  = 1'b1;
        end else begin
          ea_kind = SK_MEM;
          ea_data = reg_val;
          ea_mem  = 1'b1;
        end
      end
    endcase
  end
endmodule

// File: rtl/srcag_incr.sv
module srcag_incr #(
  parameter int DATA_W     = 16,
  parameter int WORD_BYTES = 2
) (
  input  logic [DATA_W-1:0] reg_val,
  input  logic              byte_op,
  output logic [DATA_W-1:0] next_val
);
  localparam logic [DATA_W-1:0] STEP_B = DATA_W'(1);
  localparam logic [DATA_W-1:0] STEP_W = DATA_W'(WORD_BYTES);

  assign next_val = reg_val + (byte_op ? STEP_B : STEP_W);
endmodule

// File: rtl/srcag_top.sv
module srcag_top #(
  parameter int DATA_W     = 16,
  parameter int REG_AW     = 4,
  parameter int PC_IDX     = 0,
  parameter int SR_IDX     = 2,
  parameter int CG_IDX     = 3,
  parameter int WORD_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [REG_AW-1:0] src_idx,
  input  logic [1:0]        src_mode,
  input  logic              byte_op,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [DATA_W-1:0] ext_word,
  output logic              out_valid,
  output logic [1:0]        out_kind,
  output logic [DATA_W-1:0] out_data,
  output logic              mem_req,
  output logic              ext_fetch,
  output logic              upd_en,
  output logic [DATA_W-1:0] upd_val
);
  import srcag_pkg::*;

  logic              cg_hit;
  logic [DATA_W-1:0] cg_value;
  logic [1:0]        ea_kind;
  logic [DATA_W-1:0] ea_data;
  logic              ea_mem;
  logic              ea_ext;
  logic [DATA_W-1:0] inc_val;

  logic [1:0]        nx_kind;
  logic [DATA_W-1:0] nx_data;
  logic              nx_mem;
  logic              nx_ext;
  logic              nx_upd;

  srcag_cgen #(
    .DATA_W(DATA_W), .REG_AW(REG_AW), .SR_IDX(SR_IDX), .CG_IDX(CG_IDX)
  ) u_cgen (
    .src_idx (src_idx),
    .src_mode(src_mode),
    .byte_op (byte_op),
    .cg_hit  (cg_hit),
    .cg_value(cg_value)
  );

  srcag_ea #(
    .DATA_W(DATA_W), .REG_AW(REG_AW), .PC_IDX(PC_IDX), .SR_IDX(SR_IDX)
  ) u_ea (
    .src_idx (src_idx),
    .src_mode(src_mode),
    .reg_val (reg_val),
    .ext_word(ext_word),
    .ea_kind (ea_kind),
    .ea_data (ea_data),
    .ea_mem  (ea_mem),
    .ea_ext  (ea_ext)
  );

  srcag_incr #(
    .DATA_W(DATA_W), .WORD_BYTES(WORD_BYTES)
  ) u_incr (
    .reg_val (reg_val),
    .byte_op (byte_op),
    .next_val(inc_val)
  );

  always_comb begin
    if (cg_hit) begin
      nx_kind = SK_CONST;
      nx_data = cg_value;
      nx_mem  = 1'b0;
      nx_ext  = 1'b0;
      nx_upd  = 1'b0;
    end else begin
      nx_kind = ea_kind;
      nx_data = ea_data;
      nx_mem  = ea_mem;
      nx_ext  = ea_ext;
      nx_upd  = (src_mode == MD_INC) && (src_idx != REG_AW'(PC_IDX));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_kind  <= '0;
      out_data  <= '0;
      mem_req   <= 1'b0;
      ext_fetch <= 1'b0;
      upd_en    <= 1'b0;
      upd_val   <= '0;
    end else begin
      out_valid <= in_valid;
      mem_req   <= in_valid && nx_mem;
      ext_fetch <= in_valid && nx_ext;
      upd_en    <= in_valid && nx_upd;
      if (in_valid) begin
        out_kind <= nx_kind;
        out_data <= nx_data;
        upd_val  <= inc_val;
      end
    end
  end
endmodule

// File: rtl/srcag_chk.sv
module srcag_chk #(
  parameter int DATA_W     = 16,
  parameter int REG_AW     = 4,
  parameter int WORD_BYTES = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              byte_op,
  input logic              out_valid,
  input logic [1:0]        out_kind,
  input logic [DATA_W-1:0] out_data,
  input logic              mem_req,
  input logic              ext_fetch,
  input logic              upd_en,
  input logic [DATA_W-1:0] upd_val
);
  // R8: constants are silent on memory, extension and update
  p_const_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind == 2'd2) |-> (!mem_req && !ext_fetch && !upd_en));

  // R10: strobes stay low while no result is valid
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!mem_req && !ext_fetch && !upd_en));

  // R10: one-edge latency of the valid flag
  p_latency_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_no_spurious_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R6: update step is one byte or one word past the address
  p_upd_step_r6: assert property (@(posedge clk) disable iff (rst)
    upd_en |-> ((upd_val == DATA_W'(out_data + DATA_W'(1))) ||
                (upd_val == DATA_W'(out_data + DATA_W'(WORD_BYTES)))));

  // R7: an immediate consumes the extension word and touches no memory
  p_imm_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind == 2'd3) |-> (ext_fetch && !mem_req && !upd_en));

  // R9: byte constants keep only their low 8 bits
  p_byte_const_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && byte_op) |=> (out_kind != 2'd2 || out_data[DATA_W-1:8] == '0));
endmodule

bind srcag_top srcag_chk #(
  .DATA_W(DATA_W), .REG_AW(REG_AW), .WORD_BYTES(WORD_BYTES)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .byte_op  (byte_op),
  .out_valid(out_valid),
  .out_kind (out_kind),
  .out_data (out_data),
  .mem_req  (mem_req),
  .ext_fetch(ext_fetch),
  .upd_en   (upd_en),
  .upd_val  (upd_val)
);

// File: tb/tb_srcag_top.sv
module tb_srcag_top;
  localparam int DW = 16;

  typedef struct packed {
    logic [3:0]  rn;
    logic [1:0]  md;
    logic        bw;
    logic [15:0] rv;
    logic [15:0] ex;
    logic [1:0]  k;
    logic [15:0] d;
    logic        m;
    logic        x;
    logic        u;
    logic [15:0] uv;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [0:NV-1] = '{
    '{4'd5, 2'd0, 1'b0, 16'h1234, 16'h0000, 2'd0, 16'h1234, 1'b0, 1'b0, 1'b0, 16'h0000}, // R1
    '{4'd2, 2'd0, 1'b0, 16'h0107, 16'h4444, 2'd0, 16'h0107, 1'b0, 1'b0, 1'b0, 16'h0000}, // R1
    '{4'd0, 2'd0, 1'b0, 16'hC000, 16'h0000, 2'd0, 16'hC000, 1'b0, 1'b0, 1'b0, 16'h0000}, // R1
    '{4'd5, 2'd0, 1'b1, 16'h1234, 16'h0000, 2'd0, 16'h1234, 1'b0, 1'b0, 1'b0, 16'h0000}, // R1
    '{4'd6, 2'd1, 1'b0, 16'h0200, 16'h0004, 2'd1, 16'h0204, 1'b1, 1'b1, 1'b0, 16'h0000}, // R2
    '{4'd9, 2'd1, 1'b0, 16'hFFF0, 16'h0020, 2'd1, 16'h0010, 1'b1, 1'b1, 1'b0, 16'h0000}, // R2
    '{4'd0, 2'd1, 1'b0, 16'hC010, 16'h0100, 2'd1, 16'hC110, 1'b1, 1'b1, 1'b0, 16'h0000}, // R3
    '{4'd2, 2'd1, 1'b0, 16'hABCD, 16'h0230, 2'd1, 16'h0230, 1'b1, 1'b1, 1'b0, 16'h0000}, // R4
    '{4'd7, 2'd2, 1'b0, 16'h0300, 16'h5555, 2'd1, 16'h0300, 1'b1, 1'b0, 1'b0, 16'h0000}, // R5
    '{4'd0, 2'd2, 1'b0, 16'hC020, 16'h5555, 2'd1, 16'hC020, 1'b1, 1'b0, 1'b0, 16'h0000}, // R5
    '{4'd4, 2'd3, 1'b0, 16'h0400, 16'h0000, 2'd1, 16'h0400, 1'b1, 1'b0, 1'b1, 16'h0402}, // R6
    '{4'd4, 2'd3, 1'b1, 16'h0400, 16'h0000, 2'd1, 16'h0400, 1'b1, 1'b0, 1'b1, 16'h0401}, // R6
    '{4'd8, 2'd3, 1'b0, 16'hFFFF, 16'h0000, 2'd1, 16'hFFFF, 1'b1, 1'b0, 1'b1, 16'h0001}, // R6
    '{4'd15,2'd3, 1'b1, 16'hFFFF, 16'h0000, 2'd1, 16'hFFFF, 1'b1, 1'b0, 1'b1, 16'h0000}, // R6
    '{4'd0, 2'd3, 1'b0, 16'hC030, 16'h5A5A, 2'd3, 16'h5A5A, 1'b0, 1'b1, 1'b0, 16'h0000}, // R7
    '{4'd3, 2'd0, 1'b0, 16'h7777, 16'h9999, 2'd2, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000}, // R8
    '{4'd3, 2'd1, 1'b0, 16'h7777, 16'h9999, 2'd2, 16'h0001, 1'b0, 1'b0, 1'b0, 16'h0000}, // R8
    '{4'd3, 2'd2, 1'b0, 16'h7777, 16'h9999, 2'd2, 16'h0002, 1'b0, 1'b0, 1'b0, 16'h0000}, // R8
    '{4'd3, 2'd3, 1'b0, 16'h7777, 16'h9999, 2'd2, 16'hFFFF, 1'b0, 1'b0, 1'b0, 16'h0000}, // R8
    '{4'd2, 2'd2, 1'b0, 16'h7777, 16'h9999, 2'd2, 16'h0004, 1'b0, 1'b0, 1'b0, 16'h0000}, // R8
    '{4'd2, 2'd3, 1'b0, 16'h7777, 16'h9999, 2'd2, 16'h0008, 1'b0, 1'b0, 1'b0, 16'h0000}, // R8
    '{4'd3, 2'd3, 1'b1, 16'h7777, 16'h9999, 2'd2, 16'h00FF, 1'b0, 1'b0, 1'b0, 16'h0000}, // R9
    '{4'd2, 2'd3, 1'b1, 16'h1111, 16'h2222, 2'd2, 16'h0008, 1'b0, 1'b0, 1'b0, 16'h0000}, // R9
    '{4'd3, 2'd1, 1'b1, 16'hFFFF, 16'hFFFF, 2'd2, 16'h0001, 1'b0, 1'b0, 1'b0, 16'h0000}, // R9
    '{4'd3, 2'd0, 1'b1, 16'hFFFF, 16'hFFFF, 2'd2, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000}, // R9
    '{4'd2, 2'd2, 1'b1, 16'hFFFF, 16'hFFFF, 2'd2, 16'h0004, 1'b0, 1'b0, 1'b0, 16'h0000}  // R9
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [3:0]    src_idx = '0;
  logic [1:0]    src_mode = '0;
  logic          byte_op = 1'b0;
  logic [DW-1:0] reg_val = '0;
  logic [DW-1:0] ext_word = '0;
  logic          out_valid;
  logic [1:0]    out_kind;
  logic [DW-1:0] out_data;
  logic          mem_req;
  logic          ext_fetch;
  logic          upd_en;
  logic [DW-1:0] upd_val;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  srcag_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_idx(src_idx),
    .src_mode(src_mode), .byte_op(byte_op), .reg_val(reg_val),
    .ext_word(ext_word), .out_valid(out_valid), .out_kind(out_kind),
    .out_data(out_data), .mem_req(mem_req), .ext_fetch(ext_fetch),
    .upd_en(upd_en), .upd_val(upd_val)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    src_idx  = v.rn;
    src_mode = v.md;
    byte_op  = v.bw;
    reg_val  = v.rv;
    ext_word = v.ex;
  endtask

  task automatic check_vec(input vec_t v, input string tag);
    chk({tag, " valid"}, 16'(out_valid), 16'd1);
    chk({tag, " kind"},  16'(out_kind),  16'(v.k));
    chk({tag, " data"},  out_data,       v.d);
    chk({tag, " mem"},   16'(mem_req),   16'(v.m));
    chk({tag, " ext"},   16'(ext_fetch), 16'(v.x));
    chk({tag, " upd"},   16'(upd_en),    16'(v.u));
    if (v.u) chk({tag, " upd_val"}, upd_val, v.uv);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 reset valid", 16'(out_valid), 16'd0);
    chk("R11 reset data", out_data, 16'h0000);
    chk("R11 reset strobes", {13'd0, mem_req, ext_fetch, upd_en}, 16'd0);
    rst = 1'b0;

    // table walk (R1..R9)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check_vec(VEC[i], $sformatf("vec%0d", i));
    end

    // R10: idle cycle after a request clears strobes and valid
    @(negedge clk);
    chk("R10 idle valid", 16'(out_valid), 16'd0);
    chk("R10 idle strobes", {13'd0, mem_req, ext_fetch, upd_en}, 16'd0);

    // R10: back-to-back requests, each seen one edge later
    drive(VEC[10]);
    in_valid = 1'b1;
    @(negedge clk);
    check_vec(VEC[10], "R10 b2b first");
    drive(VEC[14]);
    @(negedge clk);
    check_vec(VEC[14], "R10 b2b second");
    drive(VEC[4]);
    @(negedge clk);
    check_vec(VEC[4], "R10 b2b third");

    // R11: reset with a request present clears outputs
    drive(VEC[11]);
    rst = 1'b1;
    @(negedge clk);
    chk("R11 rst w/ req valid", 16'(out_valid), 16'd0);
    chk("R11 rst w/ req kind", 16'(out_kind), 16'd0);
    chk("R11 rst w/ req data", out_data, 16'h0000);
    chk("R11 rst w/ req upd_val", upd_val, 16'h0000);
    chk("R11 rst w/ req strobes", {13'd0, mem_req, ext_fetch, upd_en}, 16'd0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10 after reset idle", 16'(out_valid), 16'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule